// File: doc/BRIEF.md
# Configurable registered command buffer

This block is a clocked register for an address/command word. On each rising clock edge it captures a 25-bit input word and drives it onto a 28-bit output bus. Two static configuration inputs choose how the captured word is laid out on the outputs. In flat mode each input bit drives the output bit with the same index. In one of two split modes, 14 input bits each drive two output bits, doubling the fan-out.

Two active-low chip-select inputs are sampled on the same edge as the data. When both are high on an edge, the outputs keep their previous value. An active-low reset acts asynchronously: it clears the register and drives every output low at once, whatever the chip selects are doing. After reset is released, the outputs stay low until the first edge on which a chip select is low.

Top module: `cmd_reg_buf`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros. This takes effect without waiting for a clock edge and holds even when both chip selects are high.
- R2: After `rst_ni` rises, `q_o` stays zero until the first rising edge on which `cs_a_ni` or `cs_b_ni` is low.
- R3: With `sel_split_i`=0 and `sel_map_i`=0 (flat mode), a qualifying edge sets `q_o[i]` = `d_i[i]` for i = 0..24 and sets `q_o[27:25]` = 0.
- R4: The combination `sel_split_i`=0 with `sel_map_i`=1 is illegal. It produces exactly the flat-mode result of R3.
- R5: With `sel_split_i`=1 and `sel_map_i`=0 (low split), a qualifying edge sets `q_o[i]` = `q_o[i+14]` = `d_i[i]` for i = 0..13. Bits `d_i[24:14]` have no effect.
- R6: With `sel_split_i`=1 and `sel_map_i`=1 (high split), a qualifying edge sets `q_o[i]` = `q_o[i+14]` = `d_i[i+11]` for i = 0..13. Bits `d_i[10:0]` have no effect.
- R7: On a rising edge where `cs_a_ni` and `cs_b_ni` are both high, `q_o` keeps its previous value.
- R8: If either chip select is low on a rising edge, the edge updates `q_o`. With `cs_b_ni` held low, every edge loads, so the block acts as a plain register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| d_i | input | 25 | Command word input |
| cs_a_ni | input | 1 | Primary chip select, active low |
| cs_b_ni | input | 1 | Secondary chip select, active low |
| sel_map_i | input | 1 | Split mapping: 0 selects the low bits, 1 selects the high bits |
| sel_split_i | input | 1 | 0 selects flat one-to-one mode, 1 selects one-to-two split mode |
| q_o | output | 28 | Registered output bus |

## Verification
The bench builds the block with its default widths: 25 input bits and 14 bits per split half. At these widths the high-split offset of 11 and the three always-low upper outputs of flat mode are both exercised. Random words, chip-select pairs and all four configuration codes, including the illegal one, are applied across many edges. Reset is pulsed between edges while the hold is active, so the asynchronous clear and the low outputs after release can both be observed.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  typedef enum logic [1:0] {
    MAP_FLAT = 2'd0,
    MAP_LOW  = 2'd1,
    MAP_HIGH = 2'd2
  } map_e;
endpackage

// File: rtl/cmdbuf_cfg_dec.sv
module cmdbuf_cfg_dec
  import cmdbuf_pkg::*;
(
  input  logic sel_split_i,
  input  logic sel_map_i,
  output map_e mode_o
);
  // illegal split=0/map=1 folds into flat
  always_comb begin
    if (!sel_split_i)   mode_o = MAP_FLAT;
    else if (sel_map_i) mode_o = MAP_HIGH;
    else                mode_o = MAP_LOW;
  end
endmodule

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout
  import cmdbuf_pkg::*;
#(
  parameter int IN_W   = 25,
  parameter int HALF_W = 14,
  localparam int OUT_W = 2 * HALF_W,
  localparam int HI_OFS = IN_W - HALF_W
) (
  input  logic [IN_W-1:0]  d_i,
  input  map_e             mode_i,
  output logic [OUT_W-1:0] word_o
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    localparam int J = i % HALF_W;
    logic flat_bit;
    if (i < IN_W) begin : g_in
      assign flat_bit = d_i[i];
    end else begin : g_pad
      assign flat_bit = 1'b0;
    end
    always_comb begin
      unique case (mode_i)
        MAP_LOW:  word_o[i] = d_i[J];
        MAP_HIGH: word_o[i] = d_i[J+HI_OFS];
        default:  word_o[i] = flat_bit;
      endcase
    end
  end
endmodule

// File: rtl/cmdbuf_hold_reg.sv
module cmdbuf_hold_reg #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf
  import cmdbuf_pkg::*;
#(
  parameter int IN_W   = 25,
  parameter int HALF_W = 14,
  localparam int OUT_W = 2 * HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  d_i,
  input  logic             cs_a_ni,
  input  logic             cs_b_ni,
  input  logic             sel_map_i,
  input  logic             sel_split_i,
  output logic [OUT_W-1:0] q_o
);
  map_e             mode;
  logic [OUT_W-1:0] next_word;
  logic             load;

  // hold only when both selects are deasserted
  assign load = ~(cs_a_ni & cs_b_ni);

  cmdbuf_cfg_dec u_dec (
    .sel_split_i (sel_split_i),
    .sel_map_i   (sel_map_i),
    .mode_o      (mode)
  );

  cmdbuf_fanout #(.IN_W(IN_W), .HALF_W(HALF_W)) u_fan (
    .d_i    (d_i),
    .mode_i (mode),
    .word_o (next_word)
  );

  cmdbuf_hold_reg #(.W(OUT_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (load),
    .d_i    (next_word),
    .q_o    (q_o)
  );
endmodule

// File: rtl/cmdbuf_chk.sv
module cmdbuf_chk #(
  parameter int IN_W   = 25,
  parameter int HALF_W = 14,
  localparam int OUT_W = 2 * HALF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  d_i,
  input logic             cs_a_ni,
  input logic             cs_b_ni,
  input logic             sel_split_i,
  input logic [OUT_W-1:0] q_o
);
  logic upd;
  assign upd = !(cs_a_ni && cs_b_ni);

  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);

  a_r2_low_after_release: assert property (@(posedge clk_i) $rose(rst_ni) |-> q_o == '0);

  a_r3_flat_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !sel_split_i) |=> q_o[IN_W-1:0] == $past(d_i));

  a_r4_flat_pad_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !sel_split_i) |=> q_o[OUT_W-1:IN_W] == '0);

  a_r5_split_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && sel_split_i) |=> q_o[HALF_W-1:0] == q_o[OUT_W-1:HALF_W]);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_a_ni && cs_b_ni) |=> $stable(q_o));
endmodule

bind cmd_reg_buf cmdbuf_chk #(.IN_W(IN_W), .HALF_W(HALF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .d_i         (d_i),
  .cs_a_ni     (cs_a_ni),
  .cs_b_ni     (cs_b_ni),
  .sel_split_i (sel_split_i),
  .q_o         (q_o)
);

// File: tb/tb_cmd_reg_buf.sv
`timescale 1ns/1ps
module tb_cmd_reg_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [24:0] d_i = '0;
  logic        cs_a_ni = 1'b1;
  logic        cs_b_ni = 1'b1;
  logic        sel_map_i = 1'b0;
  logic        sel_split_i = 1'b0;
  logic [27:0] q_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [27:0] exp_q = '0;

  always #2.5 clk_i = ~clk_i;

  cmd_reg_buf dut (.*);

  function automatic logic [27:0] map_f(logic [24:0] d, logic c0, logic c1);
    if (!c1)     return {3'b000, d};
    else if (!c0) return {d[13:0], d[13:0]};
    else          return {d[24:11], d[24:11]};
  endfunction

  function automatic string tag_f(logic c0, logic c1, logic ca, logic cb);
    if (ca && cb) return "R7";
    if (ca && !cb) return "R8";
    if (!c1) return c0 ? "R4" : "R3";
    return c0 ? "R6" : "R5";
  endfunction

  task automatic check(string req, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [24:0] d, logic ca, logic cb, logic c0, logic c1);
    @(negedge clk_i);
    d_i = d; cs_a_ni = ca; cs_b_ni = cb; sel_map_i = c0; sel_split_i = c1;
    @(posedge clk_i);
    if (!(ca && cb)) exp_q = map_f(d, c0, c1);
    #1;
    check(tag_f(c0, c1, ca, cb), q_o, exp_q);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk_i);
    #1 check("R1", q_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    // R2: hold edge after release keeps zero
    step(25'h1ABCDEF, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3 flat, R8 secondary select loads
    step(25'h1FFFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    step(25'h0A5A5A5, 1'b1, 1'b0, 1'b0, 1'b0);
    // R4 illegal config behaves flat
    step(25'h1234567, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R4", q_o, {3'b000, 25'h1234567});
    // R5: upper bits ignored
    step(25'h0003A5C, 1'b0, 1'b1, 1'b0, 1'b1);
    step(25'h1FFFA5C | 25'h0003A5C, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R5", q_o, {14'h3A5C, 14'h3A5C});
    // R6: lower bits ignored
    step(25'h15A5800, 1'b0, 1'b1, 1'b1, 1'b1);
    step(25'h15A5FFF, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R6", q_o, {25'h15A5800 >> 11, 14'(25'h15A5800 >> 11)});
    // R7 hold across config change
    step(25'h0000000, 1'b1, 1'b1, 1'b0, 1'b0);
    // R8 plain-register run with cs_b tied low
    for (int k = 0; k < 20; k++)
      step(25'($urandom()), 1'($urandom()), 1'b0, 1'($urandom()), 1'($urandom()));
    // random mix
    for (int k = 0; k < 400; k++)
      step(25'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
    // R1: async reset mid-cycle while hold active
    step(25'h1FFFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    cs_a_ni = 1'b1; cs_b_ni = 1'b1;
    #1 rst_ni = 1'b0;
    #0.5 check("R1", q_o, '0);
    exp_q = '0;
    @(posedge clk_i); #1 check("R1", q_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    // R2: stays low on hold edges, loads on first qualifying edge
    step(25'h1FFFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R2", q_o, '0);
    step(25'h0F0F0F0, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R2", q_o, '0);
    step(25'h0F0F0F0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R2", q_o, map_f(25'h0F0F0F0, 1'b1, 1'b1));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule